// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Command Engine

This block sits in front of a fuse array of 2048 words of 32 bits. Inside the design the array is modelled as a register file that clears at reset. Software works the block through a small register window with a single-cycle write strobe and a combinational read path. It sets a mode bit to take control and loads a command code, a word address and a data word. It then raises a start bit and polls the status register until the completion flag appears.

Five operations are decoded:
- A row fetch, which returns an even/odd pair of words.
- A fuse program, which can only turn bits on.
- A program-unlock step and a program-relock command.
- An ECC switch, which acts only on a magic address/data pairing.

Programming stays refused until a four-step key has been presented through the unlock command. Each program operation takes a time that grows with the number of ones in its data word. Status reports completion, program success, the ECC state and the unlock state.

Top module: `fuse_cmd_engine`

## Requirements
- R1: While bit 0 of the mode register (offset 0x00) is 0, setting the start bit launches nothing: the done flag stays 0 and no array or read-data contents change.
- R2: With mode bit 0 set, a start bit (offset 0x08, bit 0) that is 1 while the engine is idle launches the command once. Status bit 1 (done) then rises and stays 1 for as long as start stays 1, without relaunching. Done returns to 0 one cycle after start is written to 0.
- R3: Register offsets are command 0x04 (6 bits), status 0x0C, address 0x28 (16 bits), write data 0x2C, read word 0 at 0x30 and read word 1 at 0x34. Upper bits written to a narrow register are dropped, reads are zero-extended, and writes to status or read-data offsets have no effect.
- R4: Command 0x00 reads the row selected by address bits [10:1]. Read word 0 receives the even word and read word 1 the odd word. Address bits above bit 10 are ignored.
- R5: Command 0x08, while unlocked, turns the word at address bits [10:0] into old OR data. Status bit 2 (program OK) is set only when that result equals the data word.
- R6: Command 0x08 while locked leaves the array unchanged and completes with status bit 2 clear.
- R7: Four program-enable commands (0x02) carrying write data 0x0000000F, 0x00000004, 0x00000008 and 0x0000000D in that order set status bit 4 (unlocked). A wrong value restarts the key, or resumes it at step one if the value is 0xF. Program-disable (0x03) clears bit 4 and the key progress.
- R8: Command 0x10 with address 0x001A and data 0x00EC0000 clears status bit 3 (ECC on). The same command with data 0xFF13FFFF sets bit 3. Any other address or data leaves bit 3 unchanged.
- R9: Done appears 2 + CYC_PER_BIT × popcount(data) cycles after the clock edge that stores the start bit, for an unlocked program. It appears 2 cycles after that edge for every other command, including a locked program.
- R10: Status bit 2 is cleared when any command launches.
- R11: After reset, every register reads 0 except status, which reads 0x08 (ECC on), and the array holds zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 8 | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for csr_addr |

## Verification
The bench probes the sticky start protocol. A design that relaunched while start was held would wipe program OK. A design that ignored the mode bit would raise done with the gate shut.

It also drives broken unlock keys, including a restart on 0xF, and ECC writes with the right data at the wrong address. Loose key matching would unlock early or flip ECC.

Random programs over overlapping bits, with addresses whose upper bits are dirty, expose several faults. A design that overwrote instead of ORing, judged success on the old word, or timed programs by a fixed count would each produce wrong data, a wrong program OK flag or a wrong latency.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int unsigned DW    = 32;
  localparam int unsigned OPW   = 6;
  localparam int unsigned CSR_AW = 8;

  localparam logic [CSR_AW-1:0] OFS_MODE  = 8'h00;
  localparam logic [CSR_AW-1:0] OFS_OP    = 8'h04;
  localparam logic [CSR_AW-1:0] OFS_GO    = 8'h08;
  localparam logic [CSR_AW-1:0] OFS_STAT  = 8'h0C;
  localparam logic [CSR_AW-1:0] OFS_ADDR  = 8'h28;
  localparam logic [CSR_AW-1:0] OFS_WDATA = 8'h2C;
  localparam logic [CSR_AW-1:0] OFS_RD0   = 8'h30;
  localparam logic [CSR_AW-1:0] OFS_RD1   = 8'h34;

  localparam logic [OPW-1:0] OP_READ = 6'h00;
  localparam logic [OPW-1:0] OP_PEN  = 6'h02;
  localparam logic [OPW-1:0] OP_PDIS = 6'h03;
  localparam logic [OPW-1:0] OP_PROG = 6'h08;
  localparam logic [OPW-1:0] OP_ECC  = 6'h10;

  localparam logic [15:0]   ECC_KEY_ADDR = 16'h001A;
  localparam logic [DW-1:0] ECC_OFF_KEY  = 32'h00EC0000;

  typedef enum logic [1:0] {SQ_IDLE, SQ_BUSY, SQ_DONE} sq_state_e;

  function automatic logic [5:0] ones32(input logic [DW-1:0] v);
    logic [5:0] n;
    n = '0;
    for (int i = 0; i < DW; i++) n = n + 6'(v[i]);
    return n;
  endfunction

  function automatic logic [DW-1:0] unlock_key(input logic [1:0] step);
    case (step)
      2'd0:    return 32'h0000000F;
      2'd1:    return 32'h00000004;
      2'd2:    return 32'h00000008;
      default: return 32'h0000000D;
    endcase
  endfunction
endpackage

// File: rtl/fuse_regs.sv
module fuse_regs
  import fuse_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [DW-1:0]     csr_wdata,
  input  logic [DW-1:0]     status,
  input  logic [DW-1:0]     rd0,
  input  logic [DW-1:0]     rd1,
  output logic              mode_en,
  output logic [OPW-1:0]    op,
  output logic              go,
  output logic [ADDR_W-1:0] cpu_addr,
  output logic [DW-1:0]     cpu_wdata,
  output logic [DW-1:0]     csr_rdata
);
  logic              mode_d, go_d;
  logic [OPW-1:0]    op_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DW-1:0]     wdata_d;

  always_comb begin
    mode_d  = mode_en;
    go_d    = go;
    op_d    = op;
    addr_d  = cpu_addr;
    wdata_d = cpu_wdata;
    if (csr_we) begin
      case (csr_addr)
        OFS_MODE:  mode_d  = csr_wdata[0];
        OFS_OP:    op_d    = csr_wdata[OPW-1:0];
        OFS_GO:    go_d    = csr_wdata[0];
        OFS_ADDR:  addr_d  = csr_wdata[ADDR_W-1:0];
        OFS_WDATA: wdata_d = csr_wdata;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_en   <= 1'b0;
      go        <= 1'b0;
      op        <= '0;
      cpu_addr  <= '0;
      cpu_wdata <= '0;
    end else begin
      mode_en   <= mode_d;
      go        <= go_d;
      op        <= op_d;
      cpu_addr  <= addr_d;
      cpu_wdata <= wdata_d;
    end
  end

  always_comb begin
    case (csr_addr)
      OFS_MODE:  csr_rdata = {{(DW-1){1'b0}}, mode_en};
      OFS_OP:    csr_rdata = {{(DW-OPW){1'b0}}, op};
      OFS_GO:    csr_rdata = {{(DW-1){1'b0}}, go};
      OFS_STAT:  csr_rdata = status;
      OFS_ADDR:  csr_rdata = {{(DW-ADDR_W){1'b0}}, cpu_addr};
      OFS_WDATA: csr_rdata = cpu_wdata;
      OFS_RD0:   csr_rdata = rd0;
      OFS_RD1:   csr_rdata = rd1;
      default:   csr_rdata = '0;
    endcase
  end
endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
  import fuse_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned CYC_PER_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_en,
  input  logic              go,
  input  logic [OPW-1:0]    op,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  input  logic              unlocked,
  input  logic              prog_match,
  output logic              commit,
  output logic [OPW-1:0]    job_op,
  output logic [ADDR_W-1:0] job_addr,
  output logic [DW-1:0]     job_data,
  output logic              done,
  output logic              prog_ok
);
  localparam int unsigned CNT_W = $clog2(DW * CYC_PER_BIT + 1);

  sq_state_e         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [OPW-1:0]    op_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DW-1:0]     data_d;
  logic              ok_d, fire;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    op_d   = job_op;
    addr_d = job_addr;
    data_d = job_data;
    fire   = 1'b0;
    commit = 1'b0;
    case (st_q)
      SQ_IDLE: if (mode_en && go) begin
        st_d   = SQ_BUSY;
        fire   = 1'b1;
        op_d   = op;
        addr_d = cpu_addr;
        data_d = cpu_wdata;
        cnt_d  = (op == OP_PROG && unlocked)
               ? CNT_W'(ones32(cpu_wdata)) * CNT_W'(CYC_PER_BIT) : '0;
      end
      SQ_BUSY: if (cnt_q == '0) begin
        st_d   = SQ_DONE;
        commit = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
      default: if (!go) st_d = SQ_IDLE;
    endcase
  end

  always_comb begin
    ok_d = prog_ok;
    if (fire) ok_d = 1'b0;
    else if (commit && job_op == OP_PROG) ok_d = unlocked && prog_match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SQ_IDLE;
      cnt_q    <= '0;
      job_op   <= '0;
      job_addr <= '0;
      job_data <= '0;
      prog_ok  <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      job_op   <= op_d;
      job_addr <= addr_d;
      job_data <= data_d;
      prog_ok  <= ok_d;
    end
  end

  assign done = (st_q == SQ_DONE);

  p_mode_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_IDLE && !mode_en) |=> (st_q == SQ_IDLE));
  p_done_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_DONE && go) |=> (st_q == SQ_DONE));
  p_done_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_DONE && !go) |=> (st_q == SQ_IDLE));
  p_locked_prog_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && job_op == OP_PROG && !unlocked) |=> !prog_ok);
  p_busy_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_BUSY && cnt_q != '0) |=> (st_q == SQ_BUSY && cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/fuse_keys.sv
module fuse_keys
  import fuse_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [OPW-1:0]    job_op,
  input  logic [ADDR_W-1:0] job_addr,
  input  logic [DW-1:0]     job_data,
  output logic              unlocked,
  output logic              ecc_on
);
  logic [1:0] step_q, step_d;
  logic       unl_d, ecc_d;

  always_comb begin
    step_d = step_q;
    unl_d  = unlocked;
    ecc_d  = ecc_on;
    if (commit) begin
      case (job_op)
        OP_PEN: if (!unlocked) begin
          if (job_data == unlock_key(step_q)) begin
            if (step_q == 2'd3) begin
              unl_d  = 1'b1;
              step_d = 2'd0;
            end else begin
              step_d = step_q + 2'd1;
            end
          end else begin
            step_d = (job_data == unlock_key(2'd0)) ? 2'd1 : 2'd0;
          end
        end
        OP_PDIS: begin
          unl_d  = 1'b0;
          step_d = 2'd0;
        end
        OP_ECC: if (job_addr == ADDR_W'(ECC_KEY_ADDR)) begin
          if (job_data == ECC_OFF_KEY)       ecc_d = 1'b0;
          else if (job_data == ~ECC_OFF_KEY) ecc_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q   <= 2'd0;
      unlocked <= 1'b0;
      ecc_on   <= 1'b1;
    end else begin
      step_q   <= step_d;
      unlocked <= unl_d;
      ecc_on   <= ecc_d;
    end
  end

  p_unlock_last_key_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(commit && job_op == OP_PEN && job_data == 32'h0000000D));
  p_relock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && job_op == OP_PDIS) |=> !unlocked);
  p_ecc_only_by_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ecc_on) |-> $past(commit && job_op == OP_ECC));
endmodule

// File: rtl/fuse_array.sv
module fuse_array
  import fuse_pkg::*;
#(
  parameter int unsigned WORDS = 2048,
  parameter int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [OPW-1:0]   job_op,
  input  logic [IDX_W-1:0] job_idx,
  input  logic [DW-1:0]    job_data,
  input  logic             allow_prog,
  output logic             prog_match,
  output logic [DW-1:0]    rd0,
  output logic [DW-1:0]    rd1
);
  logic [DW-1:0]    mem [WORDS];
  logic [DW-1:0]    merged;
  logic [IDX_W-1:0] even_idx, odd_idx;
  logic             do_prog, do_read;
  logic [DW-1:0]    rd0_d, rd1_d;

  assign merged     = mem[job_idx] | job_data;
  assign prog_match = (merged == job_data);
  assign even_idx   = {job_idx[IDX_W-1:1], 1'b0};
  assign odd_idx    = {job_idx[IDX_W-1:1], 1'b1};
  assign do_prog    = commit && job_op == OP_PROG && allow_prog;
  assign do_read    = commit && job_op == OP_READ;

  always_comb begin
    rd0_d = rd0;
    rd1_d = rd1;
    if (do_read) begin
      rd0_d = mem[even_idx];
      rd1_d = mem[odd_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (do_prog) begin
      mem[job_idx] <= merged;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd0 <= '0;
      rd1 <= '0;
    end else begin
      rd0 <= rd0_d;
      rd1 <= rd1_d;
    end
  end

  p_or_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    do_prog |=> ((mem[$past(job_idx)] & $past(merged)) == $past(merged)));
  p_locked_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && job_op == OP_PROG && !allow_prog) |=> $stable(mem[$past(job_idx)]));
endmodule

// File: rtl/fuse_cmd_engine.sv
module fuse_cmd_engine
  import fuse_pkg::*;
#(
  parameter int unsigned WORDS       = 2048,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned CYC_PER_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [DW-1:0]     csr_wdata,
  output logic [DW-1:0]     csr_rdata
);
  localparam int unsigned IDX_W = $clog2(WORDS);

  logic              mode_en, go, unlocked, ecc_on, prog_match;
  logic              commit, done, prog_ok;
  logic [OPW-1:0]    op, job_op;
  logic [ADDR_W-1:0] cpu_addr, job_addr;
  logic [DW-1:0]     cpu_wdata, job_data, rd0, rd1, status;

  assign status = {{(DW-5){1'b0}}, unlocked, ecc_on, prog_ok, done, 1'b0};

  fuse_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .status(status), .rd0(rd0), .rd1(rd1),
    .mode_en(mode_en), .op(op), .go(go), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .csr_rdata(csr_rdata)
  );

  fuse_seq #(.ADDR_W(ADDR_W), .CYC_PER_BIT(CYC_PER_BIT)) u_seq (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .go(go), .op(op),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .unlocked(unlocked),
    .prog_match(prog_match), .commit(commit), .job_op(job_op),
    .job_addr(job_addr), .job_data(job_data), .done(done), .prog_ok(prog_ok)
  );

  fuse_keys #(.ADDR_W(ADDR_W)) u_keys (
    .clk(clk), .rst_n(rst_n), .commit(commit), .job_op(job_op),
    .job_addr(job_addr), .job_data(job_data), .unlocked(unlocked), .ecc_on(ecc_on)
  );

  fuse_array #(.WORDS(WORDS), .IDX_W(IDX_W)) u_array (
    .clk(clk), .rst_n(rst_n), .commit(commit), .job_op(job_op),
    .job_idx(job_addr[IDX_W-1:0]), .job_data(job_data), .allow_prog(unlocked),
    .prog_match(prog_match), .rd0(rd0), .rd1(rd1)
  );
endmodule

// File: tb/fuse_cmd_engine_tb.sv
module fuse_cmd_engine_tb_top;
  localparam int CPB = 4;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [7:0]  csr_addr = 8'h00;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  int checks = 0;
  int errors = 0;
  logic [31:0] model [2048];

  always #4 clk = ~clk;

  fuse_cmd_engine #(.WORDS(2048), .ADDR_W(16), .CYC_PER_BIT(CPB)) dut_i (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata)
  );

  function automatic int popc(input logic [31:0] v);
    int n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic logic [31:0] stat_exp(input bit unl, input bit ecc, input bit ok, input bit dn);
    return {27'd0, unl, ecc, ok, dn, 1'b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    csr_addr = a;
    #1 d = csr_rdata;
  endtask

  bit unl_m = 1'b0;
  bit ecc_m = 1'b1;

  // Runs one command; returns cycles to done and the status while done.
  task automatic run_cmd(input logic [5:0] op, input logic [15:0] a, input logic [31:0] d,
                         output int cyc, output logic [31:0] st);
    logic [31:0] s2;
    wr(8'h04, {26'd0, op});
    wr(8'h28, {16'd0, a});
    wr(8'h2C, d);
    wr(8'h08, 32'd1);
    cyc = 0;
    rd(8'h0C, st);
    while (!st[1] && cyc < 1000) begin
      @(negedge clk);
      cyc++;
      rd(8'h0C, st);
    end
    repeat (3) @(negedge clk);
    rd(8'h0C, s2);
    chk("R2 done held without relaunch", s2, st);
    wr(8'h08, 32'd0);
    @(negedge clk);
    rd(8'h0C, s2);
    chk("R2 done cleared after start falls", {31'd0, s2[1]}, 32'd0);
  endtask

  task automatic prog_and_check(input logic [15:0] a, input logic [31:0] d, input string tag);
    int cyc;
    logic [31:0] st, v;
    logic [31:0] newv;
    bit ok;
    newv = model[a[10:0]] | d;
    ok = unl_m && (newv == d);
    run_cmd(6'h08, a, d, cyc, st);
    chk({tag, " R9 program latency"}, cyc, unl_m ? 2 + CPB * popc(d) : 2);
    chk({tag, " R5/R6 status"}, st, stat_exp(unl_m, ecc_m, ok, 1'b1));
    if (unl_m) model[a[10:0]] = newv;
    run_cmd(6'h00, a, 32'd0, cyc, st);
    chk({tag, " R10 ok cleared by read"}, st, stat_exp(unl_m, ecc_m, 1'b0, 1'b1));
    rd(8'h30, v);
    chk({tag, " R4 even word"}, v, model[{a[10:1], 1'b0}]);
    rd(8'h34, v);
    chk({tag, " R4 odd word"}, v, model[{a[10:1], 1'b1}]);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cyc;
    logic [31:0] st, v;
    void'($urandom(32'd17));
    for (int i = 0; i < 2048; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset values
    rd(8'h00, v); chk("R11 mode", v, 0);
    rd(8'h04, v); chk("R11 command", v, 0);
    rd(8'h08, v); chk("R11 start", v, 0);
    rd(8'h0C, v); chk("R11 status", v, 32'h8);
    rd(8'h28, v); chk("R11 address", v, 0);
    rd(8'h30, v); chk("R11 rd0", v, 0);

    // R3 widths and ignored writes
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v); chk("R3 command 6 bits", v, 32'h3F);
    wr(8'h28, 32'hABCD_1234); rd(8'h28, v); chk("R3 address 16 bits", v, 32'h1234);
    wr(8'h00, 32'hFFFF_FFFE); rd(8'h00, v); chk("R3 mode bit0 only", v, 0);
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, v); chk("R3 status not writable", v, 32'h8);
    wr(8'h30, 32'h1234_5678); rd(8'h30, v); chk("R3 rd0 not writable", v, 0);

    // R1 mode gate
    wr(8'h04, 32'h0); wr(8'h08, 32'd1);
    repeat (8) @(negedge clk);
    rd(8'h0C, v); chk("R1 no launch while mode clear", v, 32'h8);
    wr(8'h08, 32'd0);
    wr(8'h00, 32'd1);

    // R6 locked program
    prog_and_check(16'h0005, 32'h0000_00FF, "locked");

    // R7 broken keys
    run_cmd(6'h02, 0, 32'hF, cyc, st);
    run_cmd(6'h02, 0, 32'h4, cyc, st);
    run_cmd(6'h02, 0, 32'h7, cyc, st);
    run_cmd(6'h02, 0, 32'hD, cyc, st);
    chk("R7 wrong key stays locked", st[4], 1'b0);
    run_cmd(6'h02, 0, 32'hF, cyc, st);
    run_cmd(6'h02, 0, 32'hF, cyc, st);
    run_cmd(6'h02, 0, 32'h4, cyc, st);
    run_cmd(6'h02, 0, 32'h8, cyc, st);
    chk("R7 not yet unlocked", st[4], 1'b0);
    run_cmd(6'h02, 0, 32'hD, cyc, st);
    chk("R7 unlocked after F restart", st[4], 1'b1);
    chk("R9 non-program latency", cyc, 2);
    unl_m = 1'b1;

    // R5 OR semantics, directed
    prog_and_check(16'h0005, 32'h0000_00F0, "dir1");
    prog_and_check(16'hF805, 32'h0000_000F, "dir2 upper addr");
    prog_and_check(16'h0004, 32'h0000_0000, "dir3 zero");
    prog_and_check(16'h07FF, 32'hFFFF_FFFF, "dir4 all ones");

    // R8 ECC switching
    run_cmd(6'h10, 16'h001A, 32'h00EC_0000, cyc, st); chk("R8 ecc off", st[3], 1'b0); ecc_m = 1'b0;
    run_cmd(6'h10, 16'h001B, 32'hFF13_FFFF, cyc, st); chk("R8 wrong addr ignored", st[3], 1'b0);
    run_cmd(6'h10, 16'h001A, 32'hFF13_FFFF, cyc, st); chk("R8 ecc on", st[3], 1'b1); ecc_m = 1'b1;
    run_cmd(6'h10, 16'h001A, 32'h1234_5678, cyc, st); chk("R8 other data ignored", st[3], 1'b1);

    // R5/R9 random programs
    for (int k = 0; k < 30; k++) begin
      logic [15:0] a;
      logic [31:0] d;
      a = 16'($urandom);
      if (k % 3 == 0) a = {a[15:4], 4'h6};
      d = $urandom & $urandom;
      if (k % 4 == 0) d = model[a[10:0]] | 32'($urandom & 32'h0000_0F0F);
      prog_and_check(a, d, "rand");
    end

    // R7 relock
    run_cmd(6'h03, 0, 0, cyc, st);
    chk("R7 relocked", st, stat_exp(1'b0, ecc_m, 1'b0, 1'b1));
    unl_m = 1'b0;
    prog_and_check(16'h0004, 32'h8000_0001, "relocked");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule